// File: doc/BRIEF.md
# Multiplexed Seven-Segment Dimming Driver

This block scans a four-digit display of eight segments per digit (A to G and the decimal point). It enables one digit at a time and drives the segment lines of that digit with a shared pulse-width waveform that sets brightness. One period counter, advanced by an external tick enable, produces both the digit selection and the segment waveform. The digit enable therefore switches on the same clock edge on which the counter wraps. Software latency cannot delay the switch, and segments from the previous digit cannot show faintly on the next one.

The waveform is inverted. The brightness value gives the number of ticks at the start of each period during which the segments stay dark, so a larger value gives a dimmer display. The value is clamped into a guarded window that never reaches zero or the full period. A host loads the segment patterns and the brightness through two independent write strobes into shadow registers. The block copies the shadow contents into the working registers only at a period boundary. Blink and fade sequences can therefore be written at any time without glitches inside a period.

Top module: `seg_scan_dimmer`

## Requirements
- R1: From reset until the first tick, `digitEn` is all zero. After the first tick exactly one bit of `digitEn` is high in every cycle, and it does not change inside a period.
- R2: The enabled digit steps through bits 0, 1, 2, 3 and then returns to bit 0. The change happens on the edge where the period counter wraps. `periodEnd` is high for the single cycle that follows each wrap, and the start of the scan does not raise it.
- R3: In each period, an enabled segment is dark for the first L ticks and lit for the remaining PERIOD_TICKS − L ticks, where L is the working brightness value.
- R4: A written brightness value v is stored as BRIGHT_MIN if v < BRIGHT_MIN, as PERIOD_TICKS − DIM_GUARD if v exceeds that limit, and as v otherwise.
- R5: Segment s of digit d follows bit `patIn[d*8+s]`, with segment A at bit 0 through G at bit 6 and DP at bit 7. A segment whose bit is 0 stays dark for the whole period.
- R6: Pattern and brightness writes go to shadow registers. The working copies take the shadow values only at the start of the scan and at each period wrap, never in the middle of a period. `patLoad` and `lvlLoad` each update only their own shadow.
- R7: Synchronous reset turns all outputs off, clears the shadow patterns and sets the shadow brightness to the dimmest limit PERIOD_TICKS − DIM_GUARD. The scan then restarts at digit bit 0 on the first tick.
- R8: One period lasts exactly PERIOD_TICKS ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | Timebase enable; each high cycle is one tick |
| patIn | input | NUM_DIGITS*NUM_SEGS | Segment patterns of all digits, 8 bits per digit |
| patLoad | input | 1 | Write strobe for the pattern shadow |
| lvlIn | input | $clog2(PERIOD_TICKS) | Brightness value (dark ticks per period) |
| lvlLoad | input | 1 | Write strobe for the brightness shadow |
| digitEn | output | NUM_DIGITS | One-hot digit enables |
| segOut | output | NUM_SEGS | Segment drive, high means lit |
| periodEnd | output | 1 | One-cycle pulse after every digit advance |

## Verification
The embedded assertions check on every cycle that the digit enable is one-hot once scanning runs and that each `periodEnd` pulse follows a counter wrap and a single-step digit advance. They also check that the counter stays below the period, that the working brightness stays inside the clamp window, and that it holds between boundaries. Only the bench scenarios can show the brightness profile within a period: the dark-then-lit split of each segment, the darkness of segments whose pattern bit is clear, and a mid-period write appearing one period later. The same applies to the clamped values of out-of-range writes and to the dimmest default that follows a mid-run reset.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;
  // Strobes from the scan control to the segment datapath.
  typedef struct packed {
    logic loadActive;  // copy shadow registers into working registers
    logic segEnable;   // scan running, segments may light
  } scanStrobe_t;
endpackage

// File: rtl/scan_ctrl.sv
`timescale 1ns/1ps
module scan_ctrl #(
  parameter int PERIOD_TICKS = 4000,
  parameter int NUM_DIGITS   = 4,
  localparam int CNT_W       = $clog2(PERIOD_TICKS),
  localparam int DIG_W       = $clog2(NUM_DIGITS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tickEn,
  output logic [CNT_W-1:0]        cnt,
  output logic [DIG_W-1:0]        digitIdx,
  output scan_pkg::scanStrobe_t   strobe,
  output logic [NUM_DIGITS-1:0]   digitEn,
  output logic                    periodEnd
);
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(PERIOD_TICKS - 1);
  localparam logic [DIG_W-1:0] LAST_DIG  = DIG_W'(NUM_DIGITS - 1);

  logic running;
  logic lastTick;
  logic startTick;

  function automatic logic [DIG_W-1:0] nextDigit(input logic [DIG_W-1:0] cur);
    return (cur == LAST_DIG) ? '0 : cur + 1'b1;
  endfunction

  assign lastTick  = running && tickEn && (cnt == LAST_CNT);
  assign startTick = !running && tickEn;

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      cnt       <= '0;
      digitIdx  <= '0;
      periodEnd <= 1'b0;
    end else begin
      periodEnd <= lastTick;
      if (startTick) begin
        running  <= 1'b1;
        cnt      <= '0;
        digitIdx <= '0;
      end else if (lastTick) begin
        cnt      <= '0;
        digitIdx <= nextDigit(digitIdx);
      end else if (running && tickEn) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.loadActive = startTick | lastTick;
    strobe.segEnable  = running;
  end

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digitEn
    assign digitEn[d] = running && (digitIdx == DIG_W'(d));
  end

  AST_ONE_DIGIT: assert property (@(posedge clk) disable iff (rst)
    running |-> $countones(digitEn) == 1); // R1
  AST_DIGIT_STEP: assert property (@(posedge clk) disable iff (rst)
    periodEnd |-> digitIdx == nextDigit($past(digitIdx))); // R2
  AST_END_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    periodEnd |-> cnt == '0 && $past(cnt) == LAST_CNT); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_CNT); // R8
endmodule

// File: rtl/scan_datapath.sv
`timescale 1ns/1ps
module scan_datapath #(
  parameter int NUM_DIGITS = 4,
  parameter int NUM_SEGS   = 8,
  parameter int CNT_W      = 12,
  parameter int BRIGHT_MIN = 160,
  parameter int DIM_MAX    = 3900,
  localparam int DIG_W     = $clog2(NUM_DIGITS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  scan_pkg::scanStrobe_t          strobe,
  input  logic [CNT_W-1:0]               cnt,
  input  logic [DIG_W-1:0]               digitIdx,
  input  logic [NUM_DIGITS*NUM_SEGS-1:0] patIn,
  input  logic                           patLoad,
  input  logic [CNT_W-1:0]               lvlIn,
  input  logic                           lvlLoad,
  output logic [NUM_SEGS-1:0]            segOut
);
  localparam logic [CNT_W-1:0] LVL_LO = CNT_W'(BRIGHT_MIN);
  localparam logic [CNT_W-1:0] LVL_HI = CNT_W'(DIM_MAX);

  logic [NUM_SEGS-1:0] patSlice   [NUM_DIGITS];
  logic [NUM_SEGS-1:0] shadowPat  [NUM_DIGITS];
  logic [NUM_SEGS-1:0] activePat  [NUM_DIGITS];
  logic [CNT_W-1:0]    shadowLvl;
  logic [CNT_W-1:0]    activeLvl;
  logic [CNT_W-1:0]    clampedLvl;
  logic [NUM_SEGS-1:0] curPat;
  logic                pwmLit;

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_slice
    assign patSlice[d] = patIn[d*NUM_SEGS +: NUM_SEGS];
  end

  always_comb begin
    if (lvlIn < LVL_LO)      clampedLvl = LVL_LO;
    else if (lvlIn > LVL_HI) clampedLvl = LVL_HI;
    else                     clampedLvl = lvlIn;
  end

  // Shadow registers, written by the host at any time.
  always_ff @(posedge clk) begin
    if (rst) begin
      shadowLvl <= LVL_HI;
      for (int d = 0; d < NUM_DIGITS; d++) shadowPat[d] <= '0;
    end else begin
      if (lvlLoad) shadowLvl <= clampedLvl;
      if (patLoad)
        for (int d = 0; d < NUM_DIGITS; d++) shadowPat[d] <= patSlice[d];
    end
  end

  // Working registers, refreshed only at period boundaries.
  always_ff @(posedge clk) begin
    if (rst) begin
      activeLvl <= LVL_HI;
      for (int d = 0; d < NUM_DIGITS; d++) activePat[d] <= '0;
    end else if (strobe.loadActive) begin
      activeLvl <= shadowLvl;
      for (int d = 0; d < NUM_DIGITS; d++) activePat[d] <= shadowPat[d];
    end
  end

  // Inverted waveform: dark while the count is below the level.
  always_comb begin
    curPat = activePat[digitIdx];
    pwmLit = strobe.segEnable && (cnt >= activeLvl);
    segOut = pwmLit ? curPat : '0;
  end

  AST_LEVEL_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    activeLvl >= LVL_LO && activeLvl <= LVL_HI); // R4
  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadActive |=> $stable(activeLvl)); // R6
  AST_DARK_BEFORE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (strobe.segEnable && cnt == '0) |-> segOut == '0); // R3
endmodule

// File: rtl/seg_scan_dimmer.sv
`timescale 1ns/1ps
module seg_scan_dimmer #(
  parameter int PERIOD_TICKS = 4000,
  parameter int BRIGHT_MIN   = 160,
  parameter int DIM_GUARD    = 100,
  parameter int NUM_DIGITS   = 4,
  parameter int NUM_SEGS     = 8,
  localparam int CNT_W       = $clog2(PERIOD_TICKS),
  localparam int DIG_W       = $clog2(NUM_DIGITS),
  localparam int DIM_MAX     = PERIOD_TICKS - DIM_GUARD
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           tickEn,
  input  logic [NUM_DIGITS*NUM_SEGS-1:0] patIn,
  input  logic                           patLoad,
  input  logic [CNT_W-1:0]               lvlIn,
  input  logic                           lvlLoad,
  output logic [NUM_DIGITS-1:0]          digitEn,
  output logic [NUM_SEGS-1:0]            segOut,
  output logic                           periodEnd
);
  scan_pkg::scanStrobe_t strobe;
  logic [CNT_W-1:0]      cnt;
  logic [DIG_W-1:0]      digitIdx;

  scan_ctrl #(
    .PERIOD_TICKS(PERIOD_TICKS),
    .NUM_DIGITS  (NUM_DIGITS)
  ) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tickEn   (tickEn),
    .cnt      (cnt),
    .digitIdx (digitIdx),
    .strobe   (strobe),
    .digitEn  (digitEn),
    .periodEnd(periodEnd)
  );

  scan_datapath #(
    .NUM_DIGITS(NUM_DIGITS),
    .NUM_SEGS  (NUM_SEGS),
    .CNT_W     (CNT_W),
    .BRIGHT_MIN(BRIGHT_MIN),
    .DIM_MAX   (DIM_MAX)
  ) i_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .cnt     (cnt),
    .digitIdx(digitIdx),
    .patIn   (patIn),
    .patLoad (patLoad),
    .lvlIn   (lvlIn),
    .lvlLoad (lvlLoad),
    .segOut  (segOut)
  );
endmodule

// File: tb/test_seg_scan_dimmer.sv
`timescale 1ns/1ps
module test_seg_scan_dimmer;
  localparam int P      = 40;
  localparam int BMIN   = 6;
  localparam int GUARD  = 3;
  localparam int DMAX   = P - GUARD;
  localparam int CW     = $clog2(P);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic          tickEn = 1'b0;
  logic [31:0]   patIn = '0;
  logic          patLoad = 1'b0;
  logic [CW-1:0] lvlIn = '0;
  logic          lvlLoad = 1'b0;
  logic [3:0]    digitEn;
  logic [7:0]    segOut;
  logic          periodEnd;

  seg_scan_dimmer #(.PERIOD_TICKS(P), .BRIGHT_MIN(BMIN), .DIM_GUARD(GUARD))
  i_seg_scan_dimmer (
    .clk(clk), .rst(rst), .tickEn(tickEn), .patIn(patIn), .patLoad(patLoad),
    .lvlIn(lvlIn), .lvlLoad(lvlLoad), .digitEn(digitEn), .segOut(segOut),
    .periodEnd(periodEnd)
  );

  typedef struct {
    int        digit;
    logic [7:0] pat;
    int        lvl;
    string     tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] mPat;
  int          mLvl;
  int          mDigit;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clampLvl(input int v);
    if (v < BMIN) return BMIN;
    if (v > DMAX) return DMAX;
    return v;
  endfunction

  task automatic pushPeriod(input string tag);
    expItem_t it;
    it.digit = mDigit;
    it.pat   = mPat[mDigit*8 +: 8];
    it.lvl   = mLvl;
    it.tag   = tag;
    expQ.push_back(it);
  endtask

  task automatic writePat(input logic [31:0] p);
    @(negedge clk); patIn = p; patLoad = 1'b1;
    @(negedge clk); patLoad = 1'b0;
    mPat = p;
  endtask

  task automatic writeLvl(input int v);
    @(negedge clk); lvlIn = CW'(v); lvlLoad = 1'b1;
    @(negedge clk); lvlLoad = 1'b0;
    mLvl = clampLvl(v);
  endtask

  task automatic startScan(input string tag);
    @(negedge clk); tickEn = 1'b1;
    mDigit = 0;
    pushPeriod(tag);
  endtask

  // Waits for the pulse that opens the next period and predicts it.
  task automatic nextPeriod(input string tag);
    do @(negedge clk); while (!periodEnd);
    mDigit = (mDigit + 1) % 4;
    pushPeriod(tag);
  endtask

  task automatic applyReset();
    @(negedge clk); rst = 1'b1; tickEn = 1'b0;
    repeat (3) @(negedge clk);
    check(digitEn == 4'b0 && segOut == 8'b0, "R7", "outputs during reset",
          {digitEn, segOut}, 0);
    rst = 1'b0;
    expQ.delete();
    mPat = '0; mLvl = DMAX; mDigit = 0;
  endtask

  // Monitor: measures each period and compares it to the predicted item.
  int         cyc;
  int         onCnt [8];
  int         firstOn [8];
  bit         relit [8];
  logic [7:0] prevSeg;
  logic [3:0] digAtStart;
  bit         digChanged;
  bit         measuring = 0;

  task automatic finalizePeriod();
    expItem_t e;
    bit shapeOk;
    bit darkOk;
    if (expQ.size() == 0) begin
      check(0, "R2", "period with no prediction", 0, 1);
      return;
    end
    e = expQ.pop_front();
    check($countones(digAtStart) == 1 && !digChanged, "R1",
          "one-hot digit held through period", int'(digAtStart), 1 << e.digit);
    check(digAtStart == 4'(1 << e.digit), "R2", "digit order",
          int'(digAtStart), 1 << e.digit);
    check(cyc == P, "R8", "period length", cyc, P);
    shapeOk = 1; darkOk = 1;
    for (int s = 0; s < 8; s++) begin
      if (e.pat[s]) begin
        if (onCnt[s] != P - e.lvl || firstOn[s] != e.lvl || relit[s]) shapeOk = 0;
      end else if (onCnt[s] != 0) darkOk = 0;
    end
    for (int s = 0; s < 8; s++)
      if (e.pat[s] && !shapeOk) begin
        check(0, e.tag, $sformatf("seg %0d dark ticks", s), firstOn[s], e.lvl);
        break;
      end
    if (shapeOk) check(1, e.tag, "lit profile", 0, 0);
    for (int s = 0; s < 8; s++)
      if (!e.pat[s] && onCnt[s] != 0) begin
        check(0, "R5", $sformatf("seg %0d lit ticks", s), onCnt[s], 0);
        break;
      end
    if (darkOk) check(1, "R5", "masked segments dark", 0, 0);
  endtask

  always @(negedge clk) begin
    if (rst) begin
      measuring = 0;
    end else begin
      if (periodEnd && measuring) finalizePeriod();
      if (digitEn != 4'b0) begin
        if (periodEnd || !measuring) begin
          measuring = 1; cyc = 0; digAtStart = digitEn; digChanged = 0;
          prevSeg = '0;
          for (int s = 0; s < 8; s++) begin onCnt[s] = 0; firstOn[s] = -1; relit[s] = 0; end
        end
        if (digitEn != digAtStart) digChanged = 1;
        for (int s = 0; s < 8; s++) begin
          if (segOut[s]) begin
            onCnt[s]++;
            if (firstOn[s] < 0) firstOn[s] = cyc;
          end else if (prevSeg[s]) relit[s] = 1;
        end
        prevSeg = segOut;
        cyc++;
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    mPat = '0; mLvl = DMAX; mDigit = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 R7: idle before the first tick
    check(digitEn == 4'b0, "R1", "digit enables before first tick", int'(digitEn), 0);
    check(segOut == 8'b0 && periodEnd == 1'b0, "R7", "segments before first tick",
          int'(segOut), 0);

    // R3 R2: basic scan and wrap
    writePat(32'hA5_3C_81_FF);
    writeLvl(10);
    startScan("R3");
    for (int k = 0; k < 4; k++) nextPeriod("R3");

    // R6: mid-period writes become visible one period later
    writeLvl(20);
    writePat(32'h0F_F0_55_AA);
    nextPeriod("R6");
    writeLvl(30);       // level only; pattern shadow must keep its value
    nextPeriod("R6");

    // R4: clamp of out-of-range and edge values
    writeLvl(0);   nextPeriod("R4");
    writeLvl(63);  nextPeriod("R4");
    writeLvl(P);   nextPeriod("R4");
    writeLvl(BMIN - 1); nextPeriod("R4");
    writeLvl(DMAX); nextPeriod("R4");
    writeLvl(BMIN); nextPeriod("R4");
    nextPeriod("R4");

    // R7: reset mid-run, default dimmest level, restart at digit 0
    applyReset();
    check(digitEn == 4'b0, "R7", "enables after reset release", int'(digitEn), 0);
    writePat(32'hFF_FF_FF_FF);
    startScan("R7");
    for (int k = 0; k < 3; k++) nextPeriod("R7");
    do @(negedge clk); while (!periodEnd);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule